// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block passes data in both directions between an A bus and a B bus. Each direction has its own output enable, latch enable and direction clock. With those three controls a path can be transparent, it can hold a latched value, or it can act as a register that loads on the falling edge of its direction clock. The block runs entirely on a fast system clock. The two direction clocks are treated as ordinary asynchronous inputs: each one is synchronized, and its falling edge is detected inside the block.

Each direction stores its value in a single element that serves as both latch and register. While the latch enable is high, that element follows the input on every system cycle. While the latch enable is low, the element loads only on a detected falling edge of the direction clock. The output port is not a tri-state pad. It is modelled as a data bus plus a drive flag, and the data reads as zero whenever the flag is low.

Top module: `univ_bus_xcvr`

## Requirements
- R1: Each direction carries DATA_W bits, 18 by default.
- R2: When a direction's latch enable is high and its output enable is high, that direction's data output equals its data input in the same cycle. The stored value also takes the input value on every system clock edge while the latch enable is high.
- R3: When the latch enable is low and no falling edge of the direction clock is detected, the stored value does not change.
- R4: The direction clock passes through two synchronizer flops and one history flop. Take a direction clock that has been high for at least three system edges and is then driven low before system edge N. The stored value then loads the data input present at system edge N+2, provided the latch enable is low.
- R5: A rising edge of the direction clock never loads data while the latch enable is low.
- R6: The output enable alone decides whether a port is driven. When it is low, the port's drive flag is 0 and its data output is all zeros, whatever the latch enable and the clock are doing.
- R7: The two directions are independent. The controls and data of one direction never change the stored value or the outputs of the other.
- R8: When the latch enable falls, the value captured at the last system edge with the latch enable high stays on the output until a later falling edge of the direction clock.
- R9: A synchronous active-high reset clears both stored values and both synchronizers, and holds both drive flags at 0 while it is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_din | input | DATA_W | Data arriving on the A bus |
| a_dout | output | DATA_W | Data driven onto the A bus, from the B-to-A path |
| a_drive | output | 1 | High when the A bus is driven |
| b_din | input | DATA_W | Data arriving on the B bus |
| b_dout | output | DATA_W | Data driven onto the B bus, from the A-to-B path |
| b_drive | output | 1 | High when the B bus is driven |
| ab_oe | input | 1 | Output enable for the A-to-B path, active high |
| ab_le | input | 1 | Latch enable for the A-to-B path |
| ab_clk | input | 1 | A-to-B direction clock, asynchronous |
| ba_oe | input | 1 | Output enable for the B-to-A path, active high |
| ba_le | input | 1 | Latch enable for the B-to-A path |
| ba_clk | input | 1 | B-to-A direction clock, asynchronous |

## Verification
A wrong stored value shows up on the data output in the first cycle in which the output enable is high and the latch enable is low. Because of that, the stimulus keeps the output enables high most of the time. An error in the edge detector or in the synchronizer depth shifts the load point by one system cycle. That shift shows as a mismatch two or three cycles after the direction clock falls, but only when the input data changes every cycle, so the stimulus changes the data on every cycle. Crosstalk between the two directions shows up on the other port in the same cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_DATA_W = 18;
    localparam int unsigned XCVR_SYNC_STAGES = 2;

    // Per-direction control bundle as seen at the pins
    typedef struct packed {
        logic oe;
        logic le;
        logic dclk;
    } dir_ctrl_t;

    // How the storage element is updated this cycle
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_FOLLOW = 2'd1,
        UPD_EDGE   = 2'd2,
        UPD_CLEAR  = 2'd3
    } upd_kind_t;

    function automatic upd_kind_t pick_update(input logic rst_i, input logic le_i,
                                              input logic fall_i);
        if (rst_i)       return UPD_CLEAR;
        else if (le_i)   return UPD_FOLLOW;
        else if (fall_i) return UPD_EDGE;
        else             return UPD_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_fall_detect.sv
module xcvr_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    for (genvar i = 1; i < CHAIN; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    // history sample high, newest synchronized sample low
    assign fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

    // R5
    property rise_no_fall_p;
        @(posedge clk) disable iff (rst) $rose(chain_q[CHAIN-2]) |-> !fall;
    endproperty
    rise_no_fall_chk: assert property (rise_no_fall_p);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             le,
    input  logic             fall,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    upd_kind_t kind;

    always_comb kind = pick_update(rst, le, fall);

    always_ff @(posedge clk) begin
        case (kind)
            UPD_CLEAR:  q <= '0;
            UPD_FOLLOW: q <= din;
            UPD_EDGE:   q <= din;
            default:    q <= q;
        endcase
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH  = XCVR_DATA_W,
    parameter int unsigned STAGES = XCVR_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_ctrl_t        ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    logic             fall;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] view;

    xcvr_fall_detect #(.STAGES(STAGES)) u_fall (
        .clk      (clk),
        .rst      (rst),
        .async_in (ctl.dclk),
        .fall     (fall)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .le   (ctl.le),
        .fall (fall),
        .din  (din),
        .q    (q)
    );

    always_comb begin
        view  = ctl.le ? din : q;
        drive = ctl.oe & ~rst;
        dout  = drive ? view : '0;
    end

    // R2
    property follow_p;
        @(posedge clk) disable iff (rst) ctl.le |=> q == $past(din);
    endproperty
    follow_chk: assert property (follow_p);

    // R3
    property hold_p;
        @(posedge clk) disable iff (rst) (!ctl.le && !fall) |=> $stable(q);
    endproperty
    hold_chk: assert property (hold_p);

    // R4
    property edge_load_p;
        @(posedge clk) disable iff (rst) (!ctl.le && fall) |=> q == $past(din);
    endproperty
    edge_load_chk: assert property (edge_load_p);

    // R6
    property quiet_port_p;
        @(posedge clk) disable iff (rst) !ctl.oe |-> (dout == '0 && !drive);
    endproperty
    quiet_port_chk: assert property (quiet_port_p);

endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned DATA_W      = XCVR_DATA_W,
    parameter int unsigned SYNC_STAGES = XCVR_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drive,
    input  logic              ab_oe,
    input  logic              ab_le,
    input  logic              ab_clk,
    input  logic              ba_oe,
    input  logic              ba_le,
    input  logic              ba_clk
);
    localparam int unsigned NDIR = 2;

    dir_ctrl_t         ctl  [NDIR];
    logic [DATA_W-1:0] src  [NDIR];
    logic [DATA_W-1:0] dst  [NDIR];
    logic              drv  [NDIR];

    always_comb begin
        ctl[0] = '{oe: ab_oe, le: ab_le, dclk: ab_clk};
        ctl[1] = '{oe: ba_oe, le: ba_le, dclk: ba_clk};
        src[0] = a_din;
        src[1] = b_din;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        xcvr_lane #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl[d]),
            .din   (src[d]),
            .dout  (dst[d]),
            .drive (drv[d])
        );
    end

    assign b_dout  = dst[0];
    assign b_drive = drv[0];
    assign a_dout  = dst[1];
    assign a_drive = drv[1];

    // R7
    property ab_isolated_p;
        @(posedge clk) disable iff (rst)
            (ab_oe && !ab_le && $stable(ab_oe) && $stable(ab_le)
             && $past(ab_le == 1'b0) && $stable(g_dir[0].u_lane.q)) |-> $stable(b_dout);
    endproperty
    ab_isolated_chk: assert property (ab_isolated_p);

endmodule

// File: tb/univ_bus_xcvr_tb.sv
module univ_bus_xcvr_tb;
    localparam int W = 18;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst;
    logic [W-1:0] a_din, b_din, a_dout, b_dout;
    logic a_drive, b_drive;
    logic ab_oe, ab_le, ab_clk, ba_oe, ba_le, ba_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model, index 0 = A-to-B, 1 = B-to-A
    logic [W-1:0] m_q [2];
    logic [2:0]   m_sh [2];
    int           m_why [2]; // 0 reset, 1 follow, 2 edge

    univ_bus_xcvr u_dut (
        .clk(clk), .rst(rst),
        .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe(ba_oe), .ba_le(ba_le), .ba_clk(ba_clk)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] exp_out(input logic oe, input logic le, input logic r,
                                             input logic [W-1:0] din, input logic [W-1:0] q);
        if (r || !oe) return '0;
        return le ? din : q;
    endfunction

    // model update at each rising edge, from values before the edge
    always @(posedge clk) begin
        logic [W-1:0] din_v [2];
        logic le_v [2];
        logic ck_v [2];
        din_v[0] = a_din; din_v[1] = b_din;
        le_v[0] = ab_le;  le_v[1] = ba_le;
        ck_v[0] = ab_clk; ck_v[1] = ba_clk;
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_q[d] <= '0; m_sh[d] <= '0; m_why[d] <= 0;
            end else begin
                if (le_v[d]) begin
                    m_q[d] <= din_v[d]; m_why[d] <= 1;
                end else if (m_sh[d][2] && !m_sh[d][1]) begin
                    m_q[d] <= din_v[d]; m_why[d] <= 2;
                end
                m_sh[d] <= {m_sh[d][1:0], ck_v[d]};
            end
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input int d, input logic oe, input logic le);
        if (rst) return "R9";
        if (!oe) return "R6";
        if (le) return "R2";
        case (m_why[d])
            0: return "R9";
            1: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check_ports();
        check(tag_for(0, ab_oe, ab_le), b_dout, exp_out(ab_oe, ab_le, rst, a_din, m_q[0]));
        check(tag_for(1, ba_oe, ba_le), a_dout, exp_out(ba_oe, ba_le, rst, b_din, m_q[1]));
        check("R6", {17'd0, b_drive}, {17'd0, ab_oe & ~rst});
        check("R6", {17'd0, a_drive}, {17'd0, ba_oe & ~rst});
    endtask

    // one cycle: check settled outputs, then apply new inputs
    task automatic step();
        @(negedge clk);
        check_ports();
    endtask

    task automatic rand_inputs();
        a_din  = W'($urandom);
        b_din  = W'($urandom);
        ab_le  = ($urandom_range(0, 9) < 2);
        ba_le  = ($urandom_range(0, 9) < 2);
        ab_oe  = ($urandom_range(0, 9) < 8);
        ba_oe  = ($urandom_range(0, 9) < 8);
        if ($urandom_range(0, 9) < 3) ab_clk = ~ab_clk;
        if ($urandom_range(0, 9) < 3) ba_clk = ~ba_clk;
        rst    = ($urandom_range(0, 199) == 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; a_din = '1; b_din = '1;
        ab_oe = 1'b1; ab_le = 1'b0; ab_clk = 1'b0;
        ba_oe = 1'b1; ba_le = 1'b0; ba_clk = 1'b0;
        repeat (3) @(negedge clk);
        // R9: drive flags low during reset
        check("R9", {17'd0, b_drive}, '0);
        check("R9", b_dout, '0);
        rst = 1'b0;
        @(negedge clk);
        // R9: cleared storage visible once reset ends
        check("R9", b_dout, '0);
        check("R9", a_dout, '0);
        // R1
        check("R1", W'($bits(a_dout)), W'(18));

        // R2 transparent path, same cycle
        ab_le = 1'b1; a_din = 18'h2A5A5; #1;
        check("R2", b_dout, 18'h2A5A5);
        @(negedge clk);
        // R8: drop latch enable, value held
        ab_le = 1'b0; a_din = 18'h11111; #1;
        check("R8", b_dout, 18'h2A5A5);
        // R5: rising direction clock does not load
        ab_clk = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); a_din = W'(18'h30000 + i); #1;
            check("R5", b_dout, 18'h2A5A5);
        end
        // R4: fall before edge N, load at edge N+2
        ab_clk = 1'b0; a_din = 18'h00001;
        @(negedge clk); a_din = 18'h00002; #1; check("R4", b_dout, 18'h2A5A5);
        @(negedge clk); a_din = 18'h00003; #1; check("R4", b_dout, 18'h2A5A5);
        @(negedge clk); held = 18'h00003; a_din = 18'h00004; #1;
        check("R4", b_dout, held);
        // R7: activity on B-to-A does not disturb A-to-B
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ba_le = i[0]; ba_clk = ~ba_clk; b_din = W'($urandom); #1;
            check("R7", b_dout, held);
        end
        // R6: output enable low silences port regardless of latch enable
        ab_oe = 1'b0; ab_le = 1'b1; #1;
        check("R6", b_dout, '0);
        check("R6", {17'd0, b_drive}, '0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            step();
            rand_inputs();
        end
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule